// File: doc/BRIEF.md
# Bit-Sliced Pipelined Ripple Adder

This block adds two unsigned N-bit operands plus a carry input and returns the N-bit sum with a carry output. The ripple carry chain is cut by a register after every one-bit slice, so each clock period covers only one full-adder delay. A fresh operand set may be offered on every cycle. Every valid input yields exactly one result, and results come out in input order.

Slice k works on its operand bits k cycles after they arrive. The operand bits of higher slices are therefore held in short delay lines until the carry from below reaches them. The sum bits of lower slices are held until the top slice has finished. All bits of one addition then reach the outputs in the same cycle, together with a valid flag that has travelled the same path. For N bits the latency is N-1 cycles (3 at the default width of 4). The throughput is one result per cycle.

Top module: `bitslice_pipe_adder`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `out_valid` reads 0 after that edge. It stays 0 until a valid input has travelled the full latency after `rst` falls.
- R2: When `out_valid` is 1, `out_sum` equals the low WIDTH bits of `in_a + in_b + in_cin`, taken from the input set that was sampled LAT = WIDTH-1 rising edges earlier.
- R3: When `out_valid` is 1, `out_cout` equals bit WIDTH (the bit just above the sum) of that same addition.
- R4: `out_valid` is high in a cycle exactly when `in_valid` was high for the input set sampled LAT rising edges earlier.
- R5: Valid inputs offered on consecutive cycles produce valid results on consecutive cycles, with no idle cycle between them.
- R6: An input cycle with `in_valid` low produces a cycle with `out_valid` low. It does not disturb the results of the valid inputs before and after it.
- R7: A carry that is generated or entered at bit 0 reaches the carry output through every slice. For example, all-ones plus zero with carry in 1 gives sum 0 and carry out 1.
- R8: A reset asserted while additions are still in flight discards them. None of them appears on the outputs after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid flags |
| in_valid | input | 1 | Marks the current operand set as an addition to perform |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Outputs hold a finished addition |
| out_sum | output | WIDTH | Sum, modulo 2^WIDTH |
| out_cout | output | 1 | Carry out of the top bit |

## Verification
Each operand set is driven on a falling edge. Its result is due LAT rising edges later, so the bench reads it on the falling edge LAT cycles after the drive, just before that falling edge's new drive. The bench keeps every driven set, with its valid flag and its arithmetic result, in a history indexed by cycle. Each sample is compared against the entry LAT cycles back: the valid flag is checked every cycle, and the sum and carry only when that entry was valid. A reset moves the history start forward, so that entries launched before the reset are expected never to appear.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_res_t;

  function automatic fa_res_t fa_eval(input logic a, input logic b, input logic c);
    fa_res_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (c & (a ^ b));
    return r;
  endfunction

  function automatic int unsigned chain_latency(input int unsigned width);
    return (width > 0) ? width - 1 : 0;
  endfunction

endpackage

// File: rtl/bsa_slice.sv
module bsa_slice
  import bsa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);

  fa_res_t res;

  always_comb begin
    res = fa_eval(a, b, c);
  end

  assign s  = res.sum;
  assign co = res.carry;

endmodule

// File: rtl/bsa_delay.sv
module bsa_delay #(
  parameter int unsigned DEPTH    = 1,
  parameter int unsigned W        = 1,
  parameter bit          RESET_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_pass
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
      assign q = d;
    end else begin : g_shift
      logic [DEPTH-1:0][W-1:0] sr;

      always_ff @(posedge clk) begin
        if (RESET_EN && rst) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int k = 1; k < int'(DEPTH); k++) begin
            sr[k] <= sr[k-1];
          end
        end
      end

      assign q = sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/bitslice_pipe_adder.sv
module bitslice_pipe_adder
  import bsa_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_cin,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_cout
);

  localparam int unsigned LAT = chain_latency(WIDTH);

  wire [WIDTH-1:0] a_al;
  wire [WIDTH-1:0] b_al;
  wire [WIDTH-1:0] c_al;
  wire [WIDTH-1:0] s_raw;
  wire [WIDTH-1:0] co_raw;
  wire [WIDTH-1:0] sum_al;

  genvar i;
  generate
    for (i = 0; i < int'(WIDTH); i++) begin : g_bit
      // operands of slice i wait i cycles for the carry from below
      bsa_delay #(
        .DEPTH   (i),
        .W       (2),
        .RESET_EN(1'b0)
      ) u_op_dly (
        .clk(clk),
        .rst(rst),
        .d  ({in_a[i], in_b[i]}),
        .q  ({a_al[i], b_al[i]})
      );

      if (i == 0) begin : g_cin
        assign c_al[i] = in_cin;
      end else begin : g_creg
        logic carry_q;
        always_ff @(posedge clk) begin
          carry_q <= co_raw[i-1];
        end
        assign c_al[i] = carry_q;
      end

      bsa_slice u_slice (
        .a (a_al[i]),
        .b (b_al[i]),
        .c (c_al[i]),
        .s (s_raw[i]),
        .co(co_raw[i])
      );

      // lower sum bits wait for the top slice
      bsa_delay #(
        .DEPTH   (LAT - i),
        .W       (1),
        .RESET_EN(1'b0)
      ) u_sum_dly (
        .clk(clk),
        .rst(rst),
        .d  (s_raw[i]),
        .q  (sum_al[i])
      );
    end
  endgenerate

  bsa_delay #(
    .DEPTH   (LAT),
    .W       (1),
    .RESET_EN(1'b1)
  ) u_vld_dly (
    .clk(clk),
    .rst(rst),
    .d  (in_valid),
    .q  (out_valid)
  );

  assign out_sum  = sum_al;
  assign out_cout = co_raw[WIDTH-1];

endmodule

// File: rtl/bitslice_pipe_adder_chk.sv
module bitslice_pipe_adder_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             in_cin,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_cout
);

  localparam int unsigned LAT = (WIDTH > 0) ? WIDTH - 1 : 0;

  // R1: a sampled reset empties the output valid flag
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !out_valid)
    else $error("R1 out_valid high after reset");

  generate
    if (LAT > 0) begin : g_track
      logic [LAT-1:0]            vq;
      logic [LAT-1:0][WIDTH:0]   rq;
      logic [WIDTH:0]            now_res;

      assign now_res = {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_cin};

      always_ff @(posedge clk) begin
        if (rst) begin
          vq <= '0;
        end else begin
          vq[0] <= in_valid;
          for (int k = 1; k < int'(LAT); k++) vq[k] <= vq[k-1];
        end
        rq[0] <= now_res;
        for (int k = 1; k < int'(LAT); k++) rq[k] <= rq[k-1];
      end

      assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vq[LAT-1])
        else $error("R4 valid misaligned");

      assert_sum_value_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sum == rq[LAT-1][WIDTH-1:0])
        else $error("R2 sum mismatch");

      assert_carry_out_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_cout == rq[LAT-1][WIDTH])
        else $error("R3 carry mismatch");
    end else begin : g_none
      logic unused_chk;
      assign unused_chk = ^{in_valid, in_a, in_b, in_cin, out_sum, out_cout};
    end
  endgenerate

endmodule

bind bitslice_pipe_adder bitslice_pipe_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_a     (in_a),
  .in_b     (in_b),
  .in_cin   (in_cin),
  .out_valid(out_valid),
  .out_sum  (out_sum),
  .out_cout (out_cout)
);

// File: tb/bitslice_pipe_adder_tb.sv
`timescale 1ns/1ps
module bitslice_pipe_adder_tb;

  localparam int W    = 4;
  localparam int LAT  = W - 1;
  localparam int HMAX = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_sum;
  logic         out_cout;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int base   = 0;
  string scen = "R1";

  logic         hv [HMAX];
  logic [W:0]   hr [HMAX];

  always #10 clk = ~clk;

  bitslice_pipe_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
  );

  function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual %h expected %h", req, scen, cyc, got, exp);
    end
  endtask

  task automatic sample();
    int idx = cyc - LAT;
    logic ev = (idx >= base) ? hv[idx] : 1'b0;
    chk("R4", {{W{1'b0}}, out_valid}, {{W{1'b0}}, ev});
    if (ev) begin
      chk("R2", {1'b0, out_sum}, {1'b0, hr[idx][W-1:0]});
      chk("R3", {{W{1'b0}}, out_cout}, {{W{1'b0}}, hr[idx][W]});
    end
  endtask

  task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b, logic c);
    @(negedge clk);
    sample();
    rst      = 1'b0;
    in_valid = v;
    in_a     = a;
    in_b     = b;
    in_cin   = c;
    hv[cyc]  = v;
    hr[cyc]  = ref_add(a, b, c);
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    cyc++;
    for (int k = 0; k <= LAT; k++) begin
      @(negedge clk);
      cyc++;
      // R1 / R8: nothing leaves the pipe during reset
      chk("R1", {{W{1'b0}}, out_valid}, '0);
    end
    base = cyc;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    scen = "R1";
    do_reset();

    // R7: carry travels through every slice
    scen = "R7";
    step(1'b1, 4'hF, 4'h0, 1'b1);
    step(1'b1, 4'hF, 4'hF, 1'b1);
    step(1'b1, 4'h0, 4'h0, 1'b0);
    step(1'b1, 4'hF, 4'h1, 1'b0);
    step(1'b1, 4'h8, 4'h8, 1'b0);
    step(1'b1, 4'h5, 4'hA, 1'b0);

    // R5: back-to-back stream
    scen = "R5";
    for (int n = 0; n < 40; n++)
      step(1'b1, W'($urandom), W'($urandom), 1'($urandom));

    // R6: single and repeated bubbles
    scen = "R6";
    step(1'b1, 4'h3, 4'h4, 1'b1);
    step(1'b0, 4'hF, 4'hF, 1'b1);
    step(1'b1, 4'h7, 4'h9, 1'b0);
    step(1'b0, 4'h1, 4'h1, 1'b0);
    step(1'b0, 4'h2, 4'h2, 1'b0);
    step(1'b1, 4'hE, 4'h1, 1'b1);
    for (int n = 0; n < 60; n++)
      step(($urandom % 10) < 7, W'($urandom), W'($urandom), 1'($urandom));

    // R8: reset with additions in flight
    scen = "R8";
    for (int n = 0; n < 5; n++)
      step(1'b1, W'($urandom), W'($urandom), 1'($urandom));
    do_reset();
    for (int n = 0; n < 10; n++)
      step(1'b1, W'($urandom), W'($urandom), 1'($urandom));

    // R2: long mixed random run
    scen = "R2";
    for (int n = 0; n < 1500; n++)
      step(($urandom % 4) != 0, W'($urandom), W'($urandom), 1'($urandom));

    scen = "drain";
    for (int n = 0; n <= LAT; n++)
      step(1'b0, '0, '0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule